// File: doc/BRIEF.md
# Short-Descriptor Two-Level Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory in the short (32-bit word) descriptor format. A requester hands over the virtual address, the base of the first-level table and a flag that says whether the translation regime is secure. The walker then reads one or two descriptor words through a simple request/response memory port. It reports the result with a single-cycle completion pulse that carries the physical address, a 3-bit access permission, the 4-bit domain and a fault code.

Every descriptor read is tagged with the regime's secure attribute, so both walk steps land in the correct memory space. A first-level descriptor can describe a 1 MB section. It can also point to a coarse second-level table or, when the extended type-3 encoding is enabled, to a fine second-level table. The address arithmetic differs between the two table kinds. Permission and domain checks against the access type are left to the consumer of the result.

Top module: `sdesc_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, `req_ready` is high while `mem_req_valid` and `done` are low.
- R2: The first read of a walk uses the address {req_base[31:14], req_va[31:20], 2'b00}.
- R3: `mem_req_secure` equals the `req_secure` value captured when the request was accepted, on every read of that walk.
- R4: A first-level descriptor whose bits [1:0] are 0, or are 3 while `ext_type3_en` was low at acceptance, ends the walk with fault code 5 after one read. The fault result has `done_fault` high, PA 0 and AP 0.
- R5: A first-level descriptor with bits [1:0] = 2 is a section. It ends the walk after one read with code 0, PA {d[31:20], va[19:0]} and AP {d[15], d[11:10]}.
- R6: The domain output is always bits [8:5] of the first-level descriptor, whether the walk succeeds or faults.
- R7: First-level bits [1:0] = 1 select a coarse table, and the second read goes to {d[31:10], va[19:12], 2'b00}.
- R8: First-level bits [1:0] = 3 with `ext_type3_en` high select a fine table, and the second read goes to {d[31:12], va[19:10], 2'b00}.
- R9: A second-level descriptor whose bits [1:0] are 0 ends the walk with fault code 7, PA 0 and AP 0.
- R10: Second-level bits [1:0] set the page size. A value of 1 gives a 64 KB page with PA {d[31:16], va[15:0]}. A value of 2, or 3 under a coarse table, gives a 4 KB page with PA {d[31:12], va[11:0]}. A value of 3 under a fine table gives a 1 KB page with PA {d[31:10], va[9:0]}. In every case AP is {d[9], d[5:4]} and the code is 0.
- R11: `done` is high for exactly one cycle per walk. Successful results carry code 0 with `done_fault` low.
- R12: From acceptance until after `done`, `req_ready` stays low, and a request held on `req_valid` during that time is not taken.
- R13: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base (16 KB aligned) |
| req_secure | input | 1 | Translation regime is secure |
| ext_type3_en | input | 1 | First-level type 3 means fine table instead of fault |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_req_secure | output | 1 | Secure attribute of the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a translation fault |
| done_code | output | 4 | 0 success, 5 first-level fault, 7 second-level fault |
| done_pa | output | 32 | Physical address |
| done_ap | output | 3 | Access permission bits |
| done_domain | output | 4 | Domain from the first-level descriptor |

## Verification
The assertions check several rules on every cycle. They check the handshake on both sides: request refusal while busy, a held read under memory stall, and no read or pulse while idle. They also check that the secure attribute stays constant across a walk, that `done` is a single-cycle pulse, and that the fault code is always 0, 5 or 7 in agreement with the fault flag. Only the bench scenarios can show that the address arithmetic is correct for sections, coarse and fine tables, and the three page sizes. The same holds for the choice between the section fault and the page fault, and for the extended type-3 switch. The bench covers these by driving known descriptors and comparing both read addresses and the final result against values derived from the requirements.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned DOM_W  = 4;
    localparam int unsigned AP_W   = 3;
    localparam int unsigned CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_OK         = 4'd0;
    localparam logic [CODE_W-1:0] CODE_SECT_FAULT = 4'd5;
    localparam logic [CODE_W-1:0] CODE_PAGE_FAULT = 4'd7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        L1_FAULT, L1_SECTION, L1_COARSE, L1_FINE
    } l1_kind_e;

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
        logic [WORD_W-1:0] pa;
        logic [AP_W-1:0]   ap;
        logic [DOM_W-1:0]  dom;
    } walk_result_t;

    typedef struct packed {
        l1_kind_e          kind;
        logic [WORD_W-1:0] next_addr;
        walk_result_t      res;
    } l1_decode_t;

    function automatic logic [WORD_W-1:0] l1_entry_addr(
        input logic [WORD_W-1:0] base, input logic [WORD_W-1:0] va);
        return {base[31:14], va[31:20], 2'b00};
    endfunction
endpackage

// File: rtl/sdw_l1_dec.sv
module sdw_l1_dec
    import sdw_pkg::*;
(
    input  logic [WORD_W-1:0] desc,
    input  logic [WORD_W-1:0] va,
    input  logic              ext_en,
    output l1_decode_t        dec
);
    always_comb begin
        dec         = '0;
        dec.kind    = L1_FAULT;
        dec.res.dom = desc[8:5];
        case (desc[1:0])
            2'b01: begin
                dec.kind      = L1_COARSE;
                dec.next_addr = {desc[31:10], va[19:12], 2'b00};
            end
            2'b10: begin
                dec.kind    = L1_SECTION;
                dec.res.pa  = {desc[31:20], va[19:0]};
                dec.res.ap  = {desc[15], desc[11:10]};
                dec.res.code = CODE_OK;
            end
            2'b11: begin
                if (ext_en) begin
                    dec.kind      = L1_FINE;
                    dec.next_addr = {desc[31:12], va[19:10], 2'b00};
                end
            end
            default: dec.kind = L1_FAULT;
        endcase
        if (dec.kind == L1_FAULT) begin
            dec.res.fault = 1'b1;
            dec.res.code  = CODE_SECT_FAULT;
        end
    end
endmodule

// File: rtl/sdw_l2_dec.sv
module sdw_l2_dec
    import sdw_pkg::*;
(
    input  logic [WORD_W-1:0] desc,
    input  logic [WORD_W-1:0] va,
    input  logic              from_fine,
    input  logic [DOM_W-1:0]  dom,
    output walk_result_t      res
);
    always_comb begin
        res     = '0;
        res.dom = dom;
        res.ap  = {desc[9], desc[5:4]};
        case (desc[1:0])
            2'b01: res.pa = {desc[31:16], va[15:0]};
            2'b10: res.pa = {desc[31:12], va[11:0]};
            2'b11: res.pa = from_fine ? {desc[31:10], va[9:0]}
                                      : {desc[31:12], va[11:0]};
            default: begin
                res.fault = 1'b1;
                res.code  = CODE_PAGE_FAULT;
                res.ap    = '0;
            end
        endcase
    end
endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
    import sdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_va,
    input  logic [WORD_W-1:0] req_base,
    input  logic              req_secure,
    input  logic              ext_type3_en,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  l1_decode_t        l1_dec,
    input  walk_result_t      l2_res,
    output logic              req_ready,
    output logic              mem_req_valid,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic              mem_req_secure,
    output logic [WORD_W-1:0] va_q,
    output logic              ext_q,
    output logic              fine_q,
    output logic [DOM_W-1:0]  dom_q,
    output logic              done,
    output walk_result_t      res_q
);
    walk_state_e       state;
    logic [WORD_W-1:0] addr_q;
    logic              sec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            va_q   <= '0;
            addr_q <= '0;
            sec_q  <= 1'b0;
            ext_q  <= 1'b0;
            fine_q <= 1'b0;
            dom_q  <= '0;
            res_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    sec_q  <= req_secure;
                    ext_q  <= ext_type3_en;
                    addr_q <= l1_entry_addr(req_base, req_va);
                    state  <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    dom_q <= l1_dec.res.dom;
                    if (l1_dec.kind == L1_COARSE || l1_dec.kind == L1_FINE) begin
                        addr_q <= l1_dec.next_addr;
                        fine_q <= (l1_dec.kind == L1_FINE);
                        state  <= ST_L2_REQ;
                    end else begin
                        res_q <= l1_dec.res;
                        state <= ST_DONE;
                    end
                end
                ST_L2_REQ: if (mem_req_ready) state <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    res_q <= l2_res;
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready      = (state == ST_IDLE);
    assign mem_req_valid  = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign mem_req_addr   = addr_q;
    assign mem_req_secure = sec_q;
    assign done           = (state == ST_DONE);
endmodule

// File: rtl/sdesc_walker.sv
module sdesc_walker
    import sdw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_va,
    input  logic [31:0] req_base,
    input  logic        req_secure,
    input  logic        ext_type3_en,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    output logic        mem_req_secure,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done,
    output logic        done_fault,
    output logic [3:0]  done_code,
    output logic [31:0] done_pa,
    output logic [2:0]  done_ap,
    output logic [3:0]  done_domain
);
    l1_decode_t        l1_dec;
    walk_result_t      l2_res;
    walk_result_t      res_q;
    logic [WORD_W-1:0] va_q;
    logic              ext_q;
    logic              fine_q;
    logic [DOM_W-1:0]  dom_q;

    sdw_l1_dec u_l1 (
        .desc   (mem_rsp_data),
        .va     (va_q),
        .ext_en (ext_q),
        .dec    (l1_dec)
    );

    sdw_l2_dec u_l2 (
        .desc      (mem_rsp_data),
        .va        (va_q),
        .from_fine (fine_q),
        .dom       (dom_q),
        .res       (l2_res)
    );

    sdw_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_va         (req_va),
        .req_base       (req_base),
        .req_secure     (req_secure),
        .ext_type3_en   (ext_type3_en),
        .mem_req_ready  (mem_req_ready),
        .mem_rsp_valid  (mem_rsp_valid),
        .l1_dec         (l1_dec),
        .l2_res         (l2_res),
        .req_ready      (req_ready),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_req_secure (mem_req_secure),
        .va_q           (va_q),
        .ext_q          (ext_q),
        .fine_q         (fine_q),
        .dom_q          (dom_q),
        .done           (done),
        .res_q          (res_q)
    );

    assign done_fault  = res_q.fault;
    assign done_code   = res_q.code;
    assign done_pa     = res_q.pa;
    assign done_ap     = res_q.ap;
    assign done_domain = res_q.dom;
endmodule

// File: rtl/sdesc_walker_chk.sv
module sdesc_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_req_secure,
    input logic        done,
    input logic        done_fault,
    input logic [3:0]  done_code
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !done));

    // R12
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R13
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3
    secure_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_req_secure));

    // R4 R9 R11
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_fault ? (done_code == 4'd5 || done_code == 4'd7)
                             : (done_code == 4'd0)));
endmodule

bind sdesc_walker sdesc_walker_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_req_secure (mem_req_secure),
    .done           (done),
    .done_fault     (done_fault),
    .done_code      (done_code)
);

// File: tb/sdesc_walker_tb.sv
module sdesc_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] base;
        logic        sec;
        logic        ext;
        logic [31:0] l1d;
        logic [31:0] l2d;
        logic [3:0]  code;
        logic [1:0]  reads;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h1234_5678, 32'h8000_4000, 1'b0, 1'b0, 32'hABC0_8DE2, 32'h0,          4'd0, 2'd1},
        '{32'hFFF0_0ABC, 32'h0000_C000, 1'b1, 1'b0, 32'h0010_0C1E, 32'h0,          4'd0, 2'd1},
        '{32'h0300_0010, 32'h1111_0000, 1'b1, 1'b0, 32'h1234_5660, 32'h0,          4'd5, 2'd1},
        '{32'h0700_0020, 32'h2222_4000, 1'b0, 1'b0, 32'h0000_01E3, 32'h0,          4'd5, 2'd1},
        '{32'h0045_6789, 32'h3333_8000, 1'b1, 1'b0, 32'h4000_0C01, 32'h7777_7232, 4'd0, 2'd2},
        '{32'h89AB_CDEF, 32'h4444_C000, 1'b0, 1'b0, 32'h5000_0421, 32'h9999_0211, 4'd0, 2'd2},
        '{32'h0045_6789, 32'h3333_8000, 1'b0, 1'b0, 32'h4000_0C01, 32'hFFFF_FFFC, 4'd7, 2'd2},
        '{32'hABCD_EF01, 32'h5555_0000, 1'b1, 1'b1, 32'h6000_3003, 32'h2222_2A3F, 4'd0, 2'd2},
        '{32'h1357_9BDF, 32'h6666_4000, 1'b0, 1'b1, 32'h6000_3003, 32'h3333_3012, 4'd0, 2'd2},
        '{32'h2468_ACE0, 32'h7777_8000, 1'b1, 1'b1, 32'h4000_0C01, 32'h4444_4233, 4'd0, 2'd2},
        '{32'hFEDC_BA98, 32'h8888_C000, 1'b1, 1'b1, 32'h6000_3003, 32'h0,          4'd7, 2'd2},
        '{32'h1234_5678, 32'h9999_0000, 1'b1, 1'b1, 32'hABC0_8DE2, 32'h0,          4'd0, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] req_base = '0;
    logic        req_secure = 1'b0;
    logic        ext_type3_en = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_req_secure;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic        done_fault;
    logic [3:0]  done_code;
    logic [31:0] done_pa;
    logic [2:0]  done_ap;
    logic [3:0]  done_domain;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] cur_l1d = '0;
    logic [31:0] cur_l2d = '0;
    int          rd_cnt = 0;
    int          rd_base = 0;
    logic [31:0] log_addr [4];
    logic        log_sec  [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdesc_walker u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_base(req_base), .req_secure(req_secure),
        .ext_type3_en(ext_type3_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_secure(mem_req_secure),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_fault(done_fault), .done_code(done_code),
        .done_pa(done_pa), .done_ap(done_ap), .done_domain(done_domain)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst && mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= (rd_cnt == rd_base) ? cur_l1d : cur_l2d;
            if (rd_cnt - rd_base < 4) begin
                log_addr[rd_cnt - rd_base] <= mem_req_addr;
                log_sec[rd_cnt - rd_base]  <= mem_req_secure;
            end
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected values from the requirements
    task automatic model(input vec_t v, output logic [31:0] l1a, output logic [31:0] l2a,
                         output logic [31:0] pa, output logic [2:0] ap, output logic [3:0] dom);
        logic fine;
        l1a = {v.base[31:14], v.va[31:20], 2'b00};
        l2a = '0; pa = '0; ap = '0; fine = 1'b0;
        dom = v.l1d[8:5];
        if (v.l1d[1:0] == 2'd2) begin
            pa = {v.l1d[31:20], v.va[19:0]};
            ap = {v.l1d[15], v.l1d[11:10]};
        end else if (v.l1d[1:0] == 2'd1 || (v.l1d[1:0] == 2'd3 && v.ext)) begin
            fine = (v.l1d[1:0] == 2'd3);
            l2a = fine ? {v.l1d[31:12], v.va[19:10], 2'b00}
                       : {v.l1d[31:10], v.va[19:12], 2'b00};
            if (v.l2d[1:0] != 2'd0) begin
                ap = {v.l2d[9], v.l2d[5:4]};
                if (v.l2d[1:0] == 2'd1)              pa = {v.l2d[31:16], v.va[15:0]};
                else if (v.l2d[1:0] == 2'd3 && fine) pa = {v.l2d[31:10], v.va[9:0]};
                else                                 pa = {v.l2d[31:12], v.va[11:0]};
            end
        end
    endtask

    task automatic start_walk(input vec_t v);
        cur_l1d = v.l1d;
        cur_l2d = v.l2d;
        rd_base = rd_cnt;
        req_va = v.va;
        req_base = v.base;
        req_secure = v.sec;
        ext_type3_en = v.ext;
        req_valid = 1'b1;
    endtask

    task automatic wait_done(output bit seen, input bit check_busy);
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
            if (check_busy)
                check(!req_ready, "R12", "ready low while busy", 32'(req_ready), 32'd0);
        end
    endtask

    task automatic run_vec(input int idx);
        vec_t v;
        bit seen;
        logic [31:0] l1a, l2a, pa;
        logic [2:0] ap;
        logic [3:0] dom;
        v = VECS[idx];
        model(v, l1a, l2a, pa, ap, dom);
        @(negedge clk);
        start_walk(v);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen, 1'b0);
        check(seen, "R11", "done seen", 32'(seen), 32'd1);
        check(done_code == v.code, v.code == 4'd5 ? "R4" : (v.code == 4'd7 ? "R9" : "R5/R10"),
              $sformatf("vec %0d code", idx), 32'(done_code), 32'(v.code));
        check(done_fault == (v.code != 4'd0), "R11", $sformatf("vec %0d fault flag", idx),
              32'(done_fault), 32'(v.code != 4'd0));
        check(done_pa == pa, v.reads == 2'd1 ? "R5" : "R10", $sformatf("vec %0d pa", idx), done_pa, pa);
        check(done_ap == ap, v.reads == 2'd1 ? "R5" : "R10", $sformatf("vec %0d ap", idx), 32'(done_ap), 32'(ap));
        check(done_domain == dom, "R6", $sformatf("vec %0d domain", idx), 32'(done_domain), 32'(dom));
        check(rd_cnt - rd_base == int'(v.reads), "R4", $sformatf("vec %0d read count", idx),
              32'(rd_cnt - rd_base), 32'(v.reads));
        check(log_addr[0] == l1a, "R2", $sformatf("vec %0d first read addr", idx), log_addr[0], l1a);
        check(log_sec[0] == v.sec, "R3", $sformatf("vec %0d first read secure", idx),
              32'(log_sec[0]), 32'(v.sec));
        if (v.reads == 2'd2) begin
            check(log_addr[1] == l2a, v.l1d[1:0] == 2'd3 ? "R8" : "R7",
                  $sformatf("vec %0d second read addr", idx), log_addr[1], l2a);
            check(log_sec[1] == v.sec, "R3", $sformatf("vec %0d second read secure", idx),
                  32'(log_sec[1]), 32'(v.sec));
        end
        @(negedge clk);
        check(!done, "R11", "done single cycle", 32'(done), 32'd0);
        check(req_ready, "R1", "ready after walk", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit seen;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check(!mem_req_valid, "R1", "no read after reset", 32'(mem_req_valid), 32'd0);
        check(!done, "R1", "no done after reset", 32'(done), 32'd0);

        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R13: memory stall holds the read
        mem_req_ready = 1'b0;
        start_walk(VECS[4]);
        @(negedge clk);
        req_valid = 1'b0;
        held = mem_req_addr;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(mem_req_valid, "R13", "read held under stall", 32'(mem_req_valid), 32'd1);
            check(mem_req_addr == held, "R13", "address stable under stall", mem_req_addr, held);
        end
        check(rd_cnt == rd_base, "R13", "no read taken under stall", 32'(rd_cnt - rd_base), 32'd0);
        mem_req_ready = 1'b1;
        wait_done(seen, 1'b0);
        check(seen && done_code == 4'd0, "R13", "walk completes after stall", 32'(done_code), 32'd0);
        @(negedge clk);

        // R12: request held valid during the walk is refused
        start_walk(VECS[7]);
        @(negedge clk);
        wait_done(seen, 1'b1);
        req_valid = 1'b0;
        check(seen, "R12", "busy walk finished", 32'(seen), 32'd1);
        check(rd_cnt - rd_base == 2, "R12", "no extra walk while busy", 32'(rd_cnt - rd_base), 32'd2);
        @(negedge clk);
        @(negedge clk);
        check(req_ready && !mem_req_valid, "R12", "idle after dropped request",
              32'(mem_req_valid), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule